// File: doc/BRIEF.md
# Three-Level Gate Pulse Generator with Per-Phase Level Reversal

This block drives the gates of a three-phase set of neutral-point-clamped legs. Every leg has four switches and three output levels: high (P), mid (O) and low (N). A free-running triangular carrier is compared with two thresholds per phase. In the normal mode a phase runs P, then O, then N as the carrier rises, and the reverse as it falls.

Any phase can be marked for reversal. A reversed phase compares the carrier against the complements of its thresholds (half-period minus value) and then inverts the resulting four-bit pattern. It then runs N, O, P with the same dwell in each level. Choosing which phase is reversed for each sector keeps the mid level between the non-zero levels of neighbouring phases, so two phases never rest at the same non-zero level at once.

A host writes the thresholds and the reversal mask over a small address/data write port. Writes land in shadow registers, and the whole set becomes active together at the carrier valley, so each carrier period runs with one consistent set of values.

Top module: `pwm3l_gate_top`

## Requirements
- R1: After reset the carrier is 0 and counting up, every phase has low threshold 0 and high threshold HALF in both shadow and active copies, the reversal mask is clear, and every leg outputs the mid code 0110.
- R2: The carrier rises from 0 to HALF-1, holds HALF-1 for one extra cycle, falls to 0 and holds 0 for one extra cycle, so one period is 2*HALF cycles and every value appears twice.
- R3: Leg p drives gate_o[4p+3:4p] as {S1,S2,S3,S4}. With its mask bit clear it outputs P = 1100 while carrier < low, O = 0110 while low <= carrier < high, and N = 0011 otherwise. Address 2p writes the low threshold of phase p, address 2p+1 its high threshold, and address 2*NPH writes the mask (bit p for phase p).
- R4: A written threshold above HALF is stored as HALF. The high threshold in use is the larger of high and low, and when 0 < low < HALF it is raised to at least low+1.
- R5: With its mask bit set, a phase compares the carrier against HALF-high and HALF-low and inverts the pattern. It outputs N while carrier < HALF-high, O while carrier < HALF-low, and P otherwise, with each level lasting as long as in the normal mode.
- R6: Every leg always outputs one of 1100, 0110 or 0011.
- R7: Between two consecutive cycles no leg moves directly between P and N, except across the edge where new values are loaded.
- R8: Writes change only the shadow copies. Thresholds and mask are copied to the active set together at the edge that ends the cycle where the carrier is 0 while falling, so a write affects the gates only from the next period.
- R9: A normal phase with thresholds (a1,a2) and a reversed phase with (b1,b2), where a1+b1 <= HALF and a2+b2 >= HALF, never hold the same non-zero level in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe for the register port |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| carrier_o | output | CW | Current carrier count |
| gate_o | output | 4*NPH | Gate signals, four per phase, S1 in the top bit of each group |

## Verification
A wrong carrier direction or a wrong turn-around shows on carrier_o in the same cycle and shifts every gate edge after it. A shadow set that loads early or late changes the gates within one carrier period of the write, at the first carrier value where the old and new thresholds disagree. A wrong comparison or a missing inversion on a reversed phase gives an illegal four-bit code or a swapped level order on that leg within half a period. The bench therefore compares carrier and gates against its own model on every cycle.

// File: rtl/pwm3l_pkg.sv
package pwm3l_pkg;

  localparam logic [3:0] GATE_P = 4'b1100;
  localparam logic [3:0] GATE_O = 4'b0110;
  localparam logic [3:0] GATE_N = 4'b0011;

  // Upper threshold actually used: never below the lower one, and one step
  // above it when the leg visits both non-zero levels in a period.
  function automatic logic [15:0] eff_high(input logic [15:0] lo,
                                           input logic [15:0] hi,
                                           input logic [15:0] span);
    logic [15:0] h;
    h = (hi < lo) ? lo : hi;
    if ((lo != 16'd0) && (lo < span) && (h == lo))
      h = lo + 16'd1;
    return h;
  endfunction

  // Four-bit gate word {S1,S2,S3,S4} for one leg at one carrier value.
  function automatic logic [3:0] leg_gates(input logic [15:0] c,
                                           input logic [15:0] lo,
                                           input logic [15:0] hi,
                                           input logic [15:0] span,
                                           input logic        inv);
    logic [15:0] up_t;
    logic [15:0] v_lo;
    logic [15:0] v_hi;
    logic        a;
    logic        b;
    up_t = eff_high(lo, hi, span);
    if (!inv) begin
      a = (c < lo);
      b = (c < up_t);
      return {a, b, ~a, ~b};
    end
    v_lo = span - lo;
    v_hi = span - up_t;
    a = (c < v_lo);
    b = (c < v_hi);
    return ~{a, b, ~a, ~b};
  endfunction

endpackage

// File: rtl/pwm3l_carrier.sv
module pwm3l_carrier #(
  parameter int HALF = 100,
  parameter int CW   = $clog2(HALF)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [CW-1:0] cnt,
  output logic          reload
);
  localparam logic [CW-1:0] TOP = CW'(HALF - 1);

  logic rising;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      rising <= 1'b1;
    end else if (rising) begin
      if (cnt == TOP) rising <= 1'b0;
      else            cnt    <= cnt + CW'(1);
    end else begin
      if (cnt == '0)  rising <= 1'b1;
      else            cnt    <= cnt - CW'(1);
    end
  end

  // last cycle of a period: falling and at the valley
  assign reload = !rising && (cnt == '0);
endmodule

// File: rtl/pwm3l_regs.sv
module pwm3l_regs #(
  parameter int NPH  = 3,
  parameter int HALF = 100,
  parameter int TW   = $clog2(HALF + 1),
  parameter int AW   = 3,
  parameter int DW   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              load,
  output logic [NPH*TW-1:0] act_lo,
  output logic [NPH*TW-1:0] act_hi,
  output logic [NPH-1:0]    act_mask
);
  localparam logic [AW-1:0] MASK_ADDR = AW'(2 * NPH);

  logic [TW-1:0]  wval;
  logic [NPH-1:0] sh_mask;

  assign wval = (wr_data > DW'(HALF)) ? TW'(HALF) : wr_data[TW-1:0];

  for (genvar p = 0; p < NPH; p++) begin : g_ph
    logic [TW-1:0] sh_lo, sh_hi, ac_lo, ac_hi;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sh_lo <= '0;
        sh_hi <= TW'(HALF);
        ac_lo <= '0;
        ac_hi <= TW'(HALF);
      end else begin
        if (load) begin
          ac_lo <= sh_lo;
          ac_hi <= sh_hi;
        end
        if (wr_en && (wr_addr == AW'(2 * p)))     sh_lo <= wval;
        if (wr_en && (wr_addr == AW'(2 * p + 1))) sh_hi <= wval;
      end
    end

    assign act_lo[p*TW +: TW] = ac_lo;
    assign act_hi[p*TW +: TW] = ac_hi;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_mask  <= '0;
      act_mask <= '0;
    end else begin
      if (load) act_mask <= sh_mask;
      if (wr_en && (wr_addr == MASK_ADDR)) sh_mask <= wr_data[NPH-1:0];
    end
  end
endmodule

// File: rtl/pwm3l_leg.sv
module pwm3l_leg #(
  parameter int HALF = 100,
  parameter int CW   = $clog2(HALF),
  parameter int TW   = $clog2(HALF + 1)
) (
  input  logic [CW-1:0] carrier,
  input  logic [TW-1:0] lo,
  input  logic [TW-1:0] hi,
  input  logic          inv,
  output logic [3:0]    gates
);
  always_comb begin
    gates = pwm3l_pkg::leg_gates(16'(carrier), 16'(lo), 16'(hi), 16'(HALF), inv);
  end
endmodule

// File: rtl/pwm3l_gate_top.sv
module pwm3l_gate_top #(
  parameter int NPH  = 3,
  parameter int HALF = 100,
  parameter int AW   = 3,
  parameter int DW   = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AW-1:0]              wr_addr,
  input  logic [DW-1:0]              wr_data,
  output logic [$clog2(HALF)-1:0]    carrier_o,
  output logic [4*NPH-1:0]           gate_o
);
  localparam int CW = $clog2(HALF);
  localparam int TW = $clog2(HALF + 1);

  logic              period_reload;
  logic [NPH*TW-1:0] act_lo;
  logic [NPH*TW-1:0] act_hi;
  logic [NPH-1:0]    act_mask;

  pwm3l_carrier #(.HALF(HALF), .CW(CW)) u_carrier (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt    (carrier_o),
    .reload (period_reload)
  );

  pwm3l_regs #(.NPH(NPH), .HALF(HALF), .TW(TW), .AW(AW), .DW(DW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .load     (period_reload),
    .act_lo   (act_lo),
    .act_hi   (act_hi),
    .act_mask (act_mask)
  );

  for (genvar p = 0; p < NPH; p++) begin : g_leg
    pwm3l_leg #(.HALF(HALF), .CW(CW), .TW(TW)) u_leg (
      .carrier (carrier_o),
      .lo      (act_lo[p*TW +: TW]),
      .hi      (act_hi[p*TW +: TW]),
      .inv     (act_mask[p]),
      .gates   (gate_o[4*p +: 4])
    );
  end
endmodule

// File: rtl/pwm3l_gate_chk.sv
module pwm3l_gate_chk #(
  parameter int NPH  = 3,
  parameter int HALF = 100,
  parameter int CW   = $clog2(HALF),
  parameter int TW   = $clog2(HALF + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [CW-1:0]     carrier_o,
  input logic [4*NPH-1:0]  gate_o,
  input logic              period_reload,
  input logic [NPH*TW-1:0] act_lo,
  input logic [NPH*TW-1:0] act_hi,
  input logic [NPH-1:0]    act_mask
);
  AST_CARRIER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    carrier_o <= CW'(HALF - 1)); // R2

  AST_CARRIER_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (carrier_o == $past(carrier_o)) ||
    (carrier_o == $past(carrier_o) + CW'(1)) ||
    (carrier_o + CW'(1) == $past(carrier_o))); // R2

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !period_reload |=> ($stable(act_mask) && $stable(act_lo) && $stable(act_hi))); // R8

  for (genvar p = 0; p < NPH; p++) begin : g_p
    AST_GATE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      (gate_o[4*p +: 4] == 4'b1100) || (gate_o[4*p +: 4] == 4'b0110) ||
      (gate_o[4*p +: 4] == 4'b0011)); // R6

    AST_NO_P_TO_N: assert property (@(posedge clk) disable iff (!rst_n)
      (!period_reload && (gate_o[4*p +: 4] == 4'b1100)) |=> (gate_o[4*p +: 4] != 4'b0011)); // R7

    AST_NO_N_TO_P: assert property (@(posedge clk) disable iff (!rst_n)
      (!period_reload && (gate_o[4*p +: 4] == 4'b0011)) |=> (gate_o[4*p +: 4] != 4'b1100)); // R7
  end
endmodule

bind pwm3l_gate_top pwm3l_gate_chk #(.NPH(NPH), .HALF(HALF), .CW(CW), .TW(TW)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .carrier_o     (carrier_o),
  .gate_o        (gate_o),
  .period_reload (period_reload),
  .act_lo        (act_lo),
  .act_hi        (act_hi),
  .act_mask      (act_mask)
);

// File: tb/pwm3l_gate_top_tb_top.sv
`timescale 1ns/1ps
module pwm3l_gate_top_tb_top;
  localparam int NPH  = 3;
  localparam int HALF = 100;
  localparam int AW   = 3;
  localparam int DW   = 16;
  localparam int CW   = $clog2(HALF);

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [AW-1:0]     wr_addr = '0;
  logic [DW-1:0]     wr_data = '0;
  logic [CW-1:0]     carrier_o;
  logic [4*NPH-1:0]  gate_o;

  always #2 clk = ~clk;

  pwm3l_gate_top #(.NPH(NPH), .HALF(HALF), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .carrier_o(carrier_o), .gate_o(gate_o)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit cmp_en = 0;
  bit r9_en = 0;
  string cur_tag = "R3";

  // behavioural reference
  int mc;
  bit mup;
  int sh_lo[NPH], sh_hi[NPH], ac_lo[NPH], ac_hi[NPH];
  bit [NPH-1:0] sh_mask, ac_mask;
  bit m_reloaded;
  int wv;
  int prev_lv[NPH];
  bit have_prev = 0;

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // +1 = P, 0 = O, -1 = N
  function automatic int exp_level(int c, int lo, int hi, bit inv);
    int e2;
    e2 = (hi < lo) ? lo : hi;
    if (lo > 0 && lo < HALF && e2 == lo) e2 = lo + 1;
    if (!inv) begin
      if (c < lo) return 1;
      if (c < e2) return 0;
      return -1;
    end
    if (c < HALF - e2) return -1;
    if (c < HALF - lo) return 0;
    return 1;
  endfunction

  function automatic logic [3:0] code_of(int lv);
    if (lv > 0) return 4'b1100;
    if (lv == 0) return 4'b0110;
    return 4'b0011;
  endfunction

  function automatic int level_of(logic [3:0] g);
    if (g == 4'b1100) return 1;
    if (g == 4'b0110) return 0;
    if (g == 4'b0011) return -1;
    return 9;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mc = 0; mup = 1; m_reloaded = 0;
      sh_mask = '0; ac_mask = '0;
      for (int p = 0; p < NPH; p++) begin
        sh_lo[p] = 0; sh_hi[p] = HALF; ac_lo[p] = 0; ac_hi[p] = HALF;
      end
    end else begin
      m_reloaded = 0;
      if (!mup && mc == 0) begin
        for (int p = 0; p < NPH; p++) begin
          ac_lo[p] = sh_lo[p]; ac_hi[p] = sh_hi[p];
        end
        ac_mask = sh_mask;
        m_reloaded = 1;
      end
      if (wr_en) begin
        wv = (int'(wr_data) > HALF) ? HALF : int'(wr_data);
        if (int'(wr_addr) < 2*NPH) begin
          if (wr_addr[0] == 1'b0) sh_lo[int'(wr_addr)/2] = wv;
          else                    sh_hi[int'(wr_addr)/2] = wv;
        end else if (int'(wr_addr) == 2*NPH) begin
          sh_mask = wr_data[NPH-1:0];
        end
      end
      if (mup) begin
        if (mc == HALF-1) mup = 0; else mc++;
      end else begin
        if (mc == 0) mup = 1; else mc--;
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_en && !done) begin
      int lv[NPH];
      chk(int'(carrier_o) == mc, "R2", int'(carrier_o), mc);
      for (int p = 0; p < NPH; p++) begin
        logic [3:0] g;
        logic [3:0] e;
        g = gate_o[4*p +: 4];
        e = code_of(exp_level(mc, ac_lo[p], ac_hi[p], ac_mask[p]));
        chk(g == e, ac_mask[p] ? "R5" : cur_tag, int'(g), int'(e));
        lv[p] = level_of(g);
        chk(lv[p] != 9, "R6", int'(g), 6);
        if (have_prev && !m_reloaded)
          chk(!((prev_lv[p] == 1 && lv[p] == -1) || (prev_lv[p] == -1 && lv[p] == 1)),
              "R7", lv[p], prev_lv[p]);
        prev_lv[p] = lv[p];
      end
      have_prev = 1;
      if (r9_en)
        for (int i = 0; i < NPH; i++)
          for (int j = i + 1; j < NPH; j++)
            chk(!(lv[i] == lv[j] && lv[i] != 0), "R9", lv[i], 0);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_phase(input int p, input int lo, input int hi);
    wr(2*p, lo);
    wr(2*p + 1, hi);
  endtask

  task automatic run(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state before the first active edge
    chk(carrier_o == '0, "R1", int'(carrier_o), 0);
    for (int p = 0; p < NPH; p++)
      chk(gate_o[4*p +: 4] == 4'b0110, "R1", int'(gate_o[4*p +: 4]), 6);
    cmp_en = 1;

    // R3: normal order, several threshold pairs, written mid-period
    cur_tag = "R3";
    run(40);
    set_phase(0, 30, 60);
    set_phase(1, 20, 80);
    set_phase(2, 10, 90);
    // R8: shadow writes must not reach the gates yet
    @(negedge clk);
    for (int p = 0; p < NPH; p++)
      chk(gate_o[4*p +: 4] == 4'b0110, "R8", int'(gate_o[4*p +: 4]), 6);
    run(420);

    // R4: clamp, swapped thresholds, equal thresholds
    cur_tag = "R4";
    set_phase(0, 120, 0);
    set_phase(1, 70, 20);
    set_phase(2, 50, 50);
    run(420);
    set_phase(0, 0, 0);
    set_phase(1, 1, 1);
    set_phase(2, 99, 99);
    run(420);

    // R5 + R9: one reversed phase separated from a normal one
    cur_tag = "R3";
    set_phase(0, 30, 60);
    set_phase(1, 30, 40);
    set_phase(2, 0, 100);
    wr(2*NPH, 2);
    run(250);
    r9_en = 1;
    run(420);
    r9_en = 0;

    // R5: all phases reversed, mixed corners
    set_phase(0, 10, 90);
    set_phase(1, 0, 0);
    set_phase(2, 45, 55);
    wr(2*NPH, 7);
    run(420);

    // back to normal with full-P and full-N legs
    cur_tag = "R4";
    set_phase(0, 0, 0);
    set_phase(1, 100, 100);
    set_phase(2, 25, 75);
    wr(2*NPH, 0);
    run(420);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule